// File: doc/BRIEF.md
# Dual-Channel Gain-Control PWM Generator

This block produces two pulse-width-modulated gain-control pins, one for a tuner amplifier and one for an intermediate-frequency amplifier. An external RC network smooths each pin into an analogue control voltage. A shared timebase divides the crystal clock by a fixed prescale and steps an 8-bit period counter, so a duty word D gives a high time of D steps out of 256. No pin can toggle faster than one step of 16 clocks.

In loop mode each channel takes its duty from a gain word supplied by an internal control loop. That word is captured only when a 9-bit counter of ADC sample strobes wraps, which gives one capture per 512 strobes. The captured word then waits in a shadow register and is applied at the next period start, so a pulse is never cut short or stretched. The IF channel can be switched to a fixed duty held in a bus-written register. In that mode the register value is applied at every period start without waiting for a strobe block. Each pin can drive push-pull or act as an open-drain output.

Top module: `agc_pwm_dual`

## Requirements
- R1: The tuner and IF channels are independent: after a capture, the tuner duty equals `tun_gain` and the IF duty equals `if_gain`, each with no influence on the other.
- R2: The PWM period is 4096 clocks (256 steps of 16 clocks). A duty word D gives exactly D*16 high clocks per period, and every pin transition is a whole multiple of 16 clocks after the previous one.
- R3: Loop gain words are captured only on the strobe that takes the strobe counter from 511 to 0, which is every 512th strobe counted from reset. 511 strobes leave the duty unchanged.
- R4: A new duty takes effect only at a period start. A high pulse that is in progress when the duty changes keeps its old width, and the next pulse has the new width.
- R5: With `if_fixed_sel`=1 the IF duty is `if_fixed_duty`, applied at the next period start with no strobes needed. `if_gain` has no effect in this mode.
- R6: With a channel's open-drain bit at 1 its `_o` pin is held at 0 and its `_oe` pin is 1 exactly while the PWM level is low. With the bit at 0, `_oe` is held at 1 and `_o` carries the PWM level.
- R7: Reset is asynchronous and active low, and its release is synchronised. After reset both duties are 128, giving 2048 high clocks per period, and the strobe counter starts at 0.
- R8: Duty 0 keeps the level low for the whole period. Duty 255 gives a level that is low for 16 clocks per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-clock ADC sample strobe |
| tun_gain | input | 8 | Loop gain word for the tuner channel |
| if_gain | input | 8 | Loop gain word for the IF channel |
| if_fixed_sel | input | 1 | 1 selects the register duty for the IF channel |
| if_fixed_duty | input | 8 | Register-held IF duty |
| tun_od | input | 1 | Tuner pin open-drain select |
| if_od | input | 1 | IF pin open-drain select |
| tun_pwm_o | output | 1 | Tuner pin output value |
| tun_pwm_oe | output | 1 | Tuner pin output enable |
| if_pwm_o | output | 1 | IF pin output value |
| if_pwm_oe | output | 1 | IF pin output enable |

## Verification
On every cycle the assertions check four things. The pin drive respects the open-drain or push-pull setting. Shadow duties change only on the strobe-block wrap, and applied duties change only at the period wrap. Every level transition falls a multiple of 16 clocks after the previous one. The duty-to-high-time mapping, the 511-versus-512 strobe boundary, the extreme duty values, the way the fixed IF register overrides the loop word, and the intact width of a pulse whose duty changes mid-period can only be shown by the bench. It shows them by counting high clocks over whole periods and by timing individual pulses.

// File: rtl/agc_pwm_pkg.sv
package agc_pwm_pkg;
  localparam int unsigned NCH    = 2;
  localparam int unsigned CH_TUN = 0;
  localparam int unsigned CH_IF  = 1;

  typedef struct packed {
    logic o;
    logic oe;
  } pin_t;
endpackage

// File: rtl/agc_pwm_rst_sync.sv
module agc_pwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/agc_pwm_timebase.sv
module agc_pwm_timebase #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned DIV   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  always_comb begin
    step  = (pre_q == PRE_LAST);
    pre_d = step ? '0 : pre_q + 1'b1;
    cnt_d = step ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign wrap = step && (cnt_q == '1);
endmodule

// File: rtl/agc_pwm_blk.sv
module agc_pwm_blk #(
  parameter int unsigned BLK_W = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic refresh
);
  logic [BLK_W-1:0] blk_q, blk_d;

  always_comb begin
    blk_d = stb ? blk_q + 1'b1 : blk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_q <= '0;
    else        blk_q <= blk_d;
  end

  assign refresh = stb && (blk_q == '1);
endmodule

// File: rtl/agc_pwm_chan.sv
module agc_pwm_chan
  import agc_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refresh,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] loop_duty,
  input  logic             fix_sel,
  input  logic [CNT_W-1:0] fix_duty,
  input  logic             od,
  output logic [CNT_W-1:0] pend,
  output logic [CNT_W-1:0] act,
  output pin_t             pin
);
  localparam logic [CNT_W-1:0] DEF_DUTY = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] pend_q, pend_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             level;

  always_comb begin
    pend_d = refresh ? loop_duty : pend_q;
    act_d  = act_q;
    if (wrap) act_d = fix_sel ? fix_duty : pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= DEF_DUTY;
      act_q  <= DEF_DUTY;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  always_comb begin
    level  = (cnt < act_q);
    pin.o  = od ? 1'b0 : level;
    pin.oe = od ? ~level : 1'b1;
  end

  assign pend = pend_q;
  assign act  = act_q;
endmodule

// File: rtl/agc_pwm_dual.sv
module agc_pwm_dual
  import agc_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned DIV   = 16,
  parameter int unsigned BLK_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic [CNT_W-1:0] tun_gain,
  input  logic [CNT_W-1:0] if_gain,
  input  logic             if_fixed_sel,
  input  logic [CNT_W-1:0] if_fixed_duty,
  input  logic             tun_od,
  input  logic             if_od,
  output logic             tun_pwm_o,
  output logic             tun_pwm_oe,
  output logic             if_pwm_o,
  output logic             if_pwm_oe
);
  logic                      rst_sync_n;
  logic [CNT_W-1:0]          cnt;
  logic                      wrap;
  logic                      refresh;
  logic [NCH-1:0][CNT_W-1:0] loop_arr, fix_arr, pend_w, act_w;
  logic [NCH-1:0]            sel_arr, od_arr;
  pin_t [NCH-1:0]            pin_w;

  agc_pwm_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  agc_pwm_timebase #(.CNT_W(CNT_W), .DIV(DIV)) i_tb (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  agc_pwm_blk #(.BLK_W(BLK_W)) i_blk (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .stb     (smp_stb),
    .refresh (refresh)
  );

  always_comb begin
    loop_arr[CH_TUN] = tun_gain;
    loop_arr[CH_IF]  = if_gain;
    fix_arr[CH_TUN]  = '0;
    fix_arr[CH_IF]   = if_fixed_duty;
    sel_arr[CH_TUN]  = 1'b0;
    sel_arr[CH_IF]   = if_fixed_sel;
    od_arr[CH_TUN]   = tun_od;
    od_arr[CH_IF]    = if_od;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    agc_pwm_chan #(.CNT_W(CNT_W)) i_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .refresh   (refresh),
      .wrap      (wrap),
      .cnt       (cnt),
      .loop_duty (loop_arr[c]),
      .fix_sel   (sel_arr[c]),
      .fix_duty  (fix_arr[c]),
      .od        (od_arr[c]),
      .pend      (pend_w[c]),
      .act       (act_w[c]),
      .pin       (pin_w[c])
    );
  end

  assign tun_pwm_o  = pin_w[CH_TUN].o;
  assign tun_pwm_oe = pin_w[CH_TUN].oe;
  assign if_pwm_o   = pin_w[CH_IF].o;
  assign if_pwm_oe  = pin_w[CH_IF].oe;
endmodule

// File: rtl/agc_pwm_chk.sv
module agc_pwm_chk
  import agc_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned DIV   = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            od,
  input logic [NCH-1:0]            o,
  input logic [NCH-1:0]            oe,
  input logic                      refresh,
  input logic                      wrap,
  input logic [NCH-1:0][CNT_W-1:0] pend,
  input logic [NCH-1:0][CNT_W-1:0] act
);
  localparam int unsigned RUN_W = CNT_W + $clog2(DIV) + 1;

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    logic             lvl, lvl_q, seen_q;
    logic [RUN_W-1:0] run_q;

    assign lvl = od[g] ? ~oe[g] : o[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q  <= 1'b0;
        seen_q <= 1'b0;
        run_q  <= '0;
      end else begin
        lvl_q <= lvl;
        if (lvl != lvl_q) begin
          seen_q <= 1'b1;
          run_q  <= RUN_W'(1);
        end else if (run_q != '1) begin
          run_q <= run_q + 1'b1;
        end
      end
    end

    // R6: open-drain pins never drive high
    p_od_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      od[g] |-> !o[g]);
    // R6: push-pull pins always enabled
    p_pp_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !od[g] |-> oe[g]);
    // R3: shadow duty moves only after a strobe-block wrap
    p_capture_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pend[g]) |-> $past(refresh));
    // R4: applied duty moves only after a period wrap
    p_period_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act[g]) |-> $past(wrap));
    // R2: transitions are spaced by whole prescale steps
    p_step_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && (lvl != lvl_q) && (run_q != '1)) |-> ((run_q % DIV) == 0));
  end
endmodule

bind agc_pwm_dual agc_pwm_chk #(.CNT_W(CNT_W), .DIV(DIV)) i_agc_pwm_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .od      ({if_od, tun_od}),
  .o       ({if_pwm_o, tun_pwm_o}),
  .oe      ({if_pwm_oe, tun_pwm_oe}),
  .refresh (refresh),
  .wrap    (wrap),
  .pend    (pend_w),
  .act     (act_w)
);

// File: tb/test_agc_pwm_dual.sv
`timescale 1ns/1ps
module test_agc_pwm_dual;
  localparam int PERIOD = 4096;
  localparam int STEP   = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_stb;
  logic [7:0] tun_gain, if_gain, if_fixed_duty;
  logic       if_fixed_sel, tun_od, if_od;
  logic       tun_pwm_o, tun_pwm_oe, if_pwm_o, if_pwm_oe;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  agc_pwm_dual i_agc_pwm_dual (
    .clk           (clk),
    .rst_n         (rst_n),
    .smp_stb       (smp_stb),
    .tun_gain      (tun_gain),
    .if_gain       (if_gain),
    .if_fixed_sel  (if_fixed_sel),
    .if_fixed_duty (if_fixed_duty),
    .tun_od        (tun_od),
    .if_od         (if_od),
    .tun_pwm_o     (tun_pwm_o),
    .tun_pwm_oe    (tun_pwm_oe),
    .if_pwm_o      (if_pwm_o),
    .if_pwm_oe     (if_pwm_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Counts over one full period: o high, oe low, oe high for each pin
  int c_to, c_io, c_toe0, c_ioe0, c_toe1, c_ioe1;
  task automatic window();
    c_to = 0; c_io = 0; c_toe0 = 0; c_ioe0 = 0; c_toe1 = 0; c_ioe1 = 0;
    repeat (PERIOD) begin
      @(negedge clk);
      if (tun_pwm_o)  c_to++;
      if (if_pwm_o)   c_io++;
      if (!tun_pwm_oe) c_toe0++; else c_toe1++;
      if (!if_pwm_oe)  c_ioe0++; else c_ioe1++;
    end
  endtask

  task automatic strobes(input int n);
    repeat (n) begin
      @(negedge clk) smp_stb = 1'b1;
      @(negedge clk) smp_stb = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (PERIOD + 100) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R7 tun oe in reset", int'(tun_pwm_oe), 1);
    chk("R7 if oe in reset", int'(if_pwm_oe), 1);
    @(negedge clk) rst_n = 1'b1;
    repeat (10) @(negedge clk);
    window();
    chk("R7 R2 tun default duty high clocks", c_to, 128 * STEP);
    chk("R7 R2 if default duty high clocks", c_io, 128 * STEP);
  endtask

  task automatic t_gate();
    tun_gain = 8'h40; if_gain = 8'hC0;
    strobes(511);
    settle();
    window();
    chk("R3 tun after 511 strobes", c_to, 128 * STEP);
    chk("R3 if after 511 strobes", c_io, 128 * STEP);
    strobes(1);
    settle();
    window();
    chk("R3 R1 tun after 512th strobe", c_to, 8'h40 * STEP);
    chk("R3 R1 if after 512th strobe", c_io, 8'hC0 * STEP);
  endtask

  task automatic t_indep();
    tun_gain = 8'hA0;
    strobes(512);
    settle();
    window();
    chk("R1 tun new word", c_to, 8'hA0 * STEP);
    chk("R1 if unchanged word", c_io, 8'hC0 * STEP);
  endtask

  task automatic t_bounds();
    tun_gain = 8'h00; if_gain = 8'hFF;
    strobes(512);
    settle();
    window();
    chk("R8 tun duty 0 high clocks", c_to, 0);
    chk("R8 if duty 255 high clocks", c_io, 255 * STEP);
  endtask

  task automatic t_fixed();
    if_fixed_sel = 1'b1; if_fixed_duty = 8'h20; if_gain = 8'h70;
    strobes(512);
    settle();
    window();
    chk("R5 if fixed duty, loop word ignored", c_io, 8'h20 * STEP);
    if_fixed_duty = 8'h60;
    settle();
    window();
    chk("R5 if fixed duty without strobes", c_io, 8'h60 * STEP);
  endtask

  task automatic t_glitch();
    int n;
    if_fixed_duty = 8'h30;
    settle();
    while (if_pwm_o !== 1'b0) @(negedge clk);
    while (if_pwm_o !== 1'b1) @(negedge clk);
    n = 0;
    while (if_pwm_o === 1'b1) begin
      n++;
      if (n == 100) if_fixed_duty = 8'h90;
      @(negedge clk);
    end
    chk("R4 pulse in progress keeps old width", n, 8'h30 * STEP);
    while (if_pwm_o !== 1'b1) @(negedge clk);
    n = 0;
    while (if_pwm_o === 1'b1) begin
      n++;
      @(negedge clk);
    end
    chk("R4 next pulse has new width", n, 8'h90 * STEP);
  endtask

  task automatic t_od();
    tun_od = 1'b1; if_od = 1'b1;
    repeat (20) @(negedge clk);
    window();
    chk("R6 tun open-drain o high clocks", c_to, 0);
    chk("R6 if open-drain o high clocks", c_io, 0);
    chk("R6 if open-drain oe low clocks", c_ioe0, 8'h90 * STEP);
    chk("R6 tun open-drain oe low clocks (duty 0)", c_toe0, 0);
    tun_od = 1'b0; if_od = 1'b0;
    repeat (20) @(negedge clk);
    window();
    chk("R6 tun push-pull oe high clocks", c_toe1, PERIOD);
    chk("R6 if push-pull oe high clocks", c_ioe1, PERIOD);
    chk("R6 if push-pull o high clocks", c_io, 8'h90 * STEP);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_stb = 1'b0;
    tun_gain = 8'h00; if_gain = 8'h00;
    if_fixed_sel = 1'b0; if_fixed_duty = 8'h00;
    tun_od = 1'b0; if_od = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_gate();
    t_indep();
    t_bounds();
    t_fixed();
    t_glitch();
    t_od();
    summary();
    $finish;
  end
endmodule